// File: doc/BRIEF.md
# Monitor Channel Byte Controller

This block moves single bytes across the monitor field of a frame-based layer-1 serial link. Once per frame, an outside frame timing unit pulses a strobe. On that strobe the block samples the incoming monitor byte and its two handshake bits. In the same cycle it loads the byte and bits it will drive for the following frame. Both handshake bits are active low. The E bit marks that the sender is offering a byte. The A bit is the receiver's acknowledgement. Outside strobes the line side is frozen, so the block works only while frames are being exchanged.

Each direction runs in one of two modes. In transparent mode, bytes and bits pass without interpretation. In protocol mode, the handshake is sequenced. The transmitter holds each byte until it is acknowledged and marks end of message with the E bit idle. The receiver acknowledges each stored byte once and withholds the acknowledgement while the host has not emptied its buffer. Two host command pulses recover from a stuck handshake. One sends an abort on the E bit. The other sends an abort request on the A bit. A loopback input feeds the block's own transmit values to its receiver.

Host data uses valid/ready streams with a one-byte buffer in each direction. The transmit buffer accepts a byte only when `s_tx_valid` and `s_tx_ready` are both high at a clock edge, and `s_tx_ready` stays low while the buffer holds a byte. The receive buffer presents a byte while `m_rx_valid` is high and is emptied when `m_rx_ready` is high at an edge. The block never drops a byte once it has been accepted into a buffer, except on a timeout or when the channel is disabled.

Top module: `gci_mon_ctrl`

## Requirements
- R1: `line_tx_mon`, `line_tx_e_n` and `line_tx_a_n` change only in the cycle after a `frame_stb` cycle, or after their channel is disabled. Otherwise they hold.
- R2: In transparent transmit mode, a strobe that finds a buffered byte drives that byte with E low for the next frame and frees the buffer. A strobe with an empty buffer drives the idle frame: all-ones byte, E high. `s_tx_ready` is high only when the transmitter is enabled and its buffer is empty.
- R3: In protocol transmit mode, a byte stays on the line with E low until a strobe samples A low. The next buffered byte then follows at once. If none is buffered, E stays high with the idle byte for at least two frames.
- R4: A `cmd_timeout` pulse makes the next frame an abort (all-ones byte with E low). It empties the transmit buffer and returns the transmitter to idle, so the following frame is idle.
- R5: In protocol receive mode, a `cmd_abort_req` pulse drives A low for exactly the next two frames, after which A returns high.
- R6: A protocol transmitter waiting for acknowledgement that samples A low on two consecutive strobes treats this as an abort request. It goes idle (idle frame next) and sets `abort_flag`.
- R7: In transparent receive mode, every strobe that finds the receive buffer empty stores the byte with its raw A and E bits. While the buffer is full, new frames are dropped and the stored byte is kept. A host read in the same cycle as a strobe counts as empty, so the new frame is stored.
- R8: In protocol receive mode, a frame with E low is stored only if the buffer is empty (or is being read in that cycle). A is then driven low for exactly the next frame. The frame after a store is never stored. A frame that finds the buffer full is neither stored nor acknowledged. Frames with E high are ignored.
- R9: In protocol receive mode, a frame with E low and an all-ones byte is a received abort. Nothing is stored, nothing is acknowledged, and `abort_flag` is set. An `abort_clr` pulse clears the flag.
- R10: `irq` is high exactly while `cfg_irq_en` is high and a received byte waits in the receive buffer.
- R11: With `cfg_loop` high, the receiver and the transmitter's acknowledgement input see the block's own line outputs instead of the line inputs. The line outputs are still driven.
- R12: Clearing a channel's enable empties its buffer, lowers its ready/valid, and drives the idle value on its line outputs (byte all ones, E high, A high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Layer-1 derived clock |
| rst_n | input | 1 | Active-low reset |
| frame_stb | input | 1 | One-cycle pulse per frame from the frame timing unit |
| cfg_tx_en | input | 1 | Transmit channel enable |
| cfg_tx_proto | input | 1 | Transmit mode: 1 protocol, 0 transparent |
| cfg_rx_en | input | 1 | Receive channel enable |
| cfg_rx_proto | input | 1 | Receive mode: 1 protocol, 0 transparent |
| cfg_loop | input | 1 | Internal loopback of transmit to receive |
| cfg_irq_en | input | 1 | Interrupt mask (1 enables) |
| cmd_timeout | input | 1 | Pulse: send abort on E |
| cmd_abort_req | input | 1 | Pulse: send abort request on A |
| abort_clr | input | 1 | Pulse: clear the abort flag |
| s_tx_valid | input | 1 | Transmit byte offered |
| s_tx_data | input | 8 | Transmit byte |
| s_tx_ready | output | 1 | Transmit buffer can accept |
| m_rx_valid | output | 1 | Received byte waiting |
| m_rx_data | output | 8 | Received byte |
| m_rx_a_n | output | 1 | A bit captured with the byte |
| m_rx_e_n | output | 1 | E bit captured with the byte |
| m_rx_ready | input | 1 | Host takes the received byte |
| line_rx_mon | input | 8 | Incoming monitor byte |
| line_rx_a_n | input | 1 | Incoming A bit, active low |
| line_rx_e_n | input | 1 | Incoming E bit, active low |
| line_tx_mon | output | 8 | Outgoing monitor byte |
| line_tx_a_n | output | 1 | Outgoing A bit, active low |
| line_tx_e_n | output | 1 | Outgoing E bit, active low |
| irq | output | 1 | Maskable receive interrupt |
| abort_flag | output | 1 | Sticky abort status |

## Verification
The collision that matters most is a host read of the receive buffer landing in the same cycle as a frame strobe that brings a new byte. The bench raises `m_rx_ready` and `frame_stb` together while the transparent receiver holds a byte. It then expects the new byte, not the old one and not an empty buffer. It also checks the protocol receiver the other way round: a strobe that finds the buffer full must neither store nor acknowledge, and the same byte must be taken and acknowledged after a plain read.

// File: rtl/gci_mon_pkg.sv
`timescale 1ns/1ps
package gci_mon_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_EOM  = 2'd2
  } tx_state_t;
endpackage

// File: rtl/gci_mon_tx.sv
`timescale 1ns/1ps
module gci_mon_tx
  import gci_mon_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic         en,
  input  logic         proto,
  input  logic         cmd_timeout,
  input  logic         s_valid,
  input  logic [W-1:0] s_data,
  output logic         s_ready,
  input  logic         far_a_n,
  output logic [W-1:0] mon_o,
  output logic         e_n_o,
  output logic         arq_seen
);
  localparam logic [W-1:0] IDLE_BYTE = {W{1'b1}};

  tx_state_t   st_q, st_d;
  logic [W-1:0] buf_q, mon_q, mon_d;
  logic        full_q, e_n_q, e_d, to_pend_q, a_prev_q;
  logic        take, arq_c, a_act, to_now, push;

  assign a_act   = ~far_a_n;
  assign to_now  = to_pend_q | cmd_timeout;
  assign s_ready = en & ~full_q;
  assign push    = s_valid & s_ready;

  always_comb begin
    st_d  = st_q;
    mon_d = mon_q;
    e_d   = e_n_q;
    take  = 1'b0;
    arq_c = 1'b0;
    if (to_now) begin
      mon_d = IDLE_BYTE;
      e_d   = 1'b0;
      st_d  = TX_IDLE;
      take  = full_q;
    end else if (!proto) begin
      st_d = TX_IDLE;
      if (full_q) begin
        mon_d = buf_q; e_d = 1'b0; take = 1'b1;
      end else begin
        mon_d = IDLE_BYTE; e_d = 1'b1;
      end
    end else begin
      case (st_q)
        TX_IDLE: begin
          if (full_q) begin
            mon_d = buf_q; e_d = 1'b0; take = 1'b1; st_d = TX_WAIT;
          end else begin
            mon_d = IDLE_BYTE; e_d = 1'b1;
          end
        end
        TX_WAIT: begin
          if (a_act && a_prev_q) begin
            arq_c = 1'b1; st_d = TX_IDLE;
            mon_d = IDLE_BYTE; e_d = 1'b1;
          end else if (a_act) begin
            if (full_q) begin
              mon_d = buf_q; e_d = 1'b0; take = 1'b1;
            end else begin
              mon_d = IDLE_BYTE; e_d = 1'b1; st_d = TX_EOM;
            end
          end
        end
        TX_EOM: begin
          mon_d = IDLE_BYTE; e_d = 1'b1; st_d = TX_IDLE;
        end
        default: st_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= TX_IDLE; buf_q <= '0; full_q <= 1'b0; to_pend_q <= 1'b0;
      a_prev_q <= 1'b0; mon_q <= IDLE_BYTE; e_n_q <= 1'b1;
    end else if (!en) begin
      st_q <= TX_IDLE; full_q <= 1'b0; to_pend_q <= 1'b0;
      a_prev_q <= 1'b0; mon_q <= IDLE_BYTE; e_n_q <= 1'b1;
    end else begin
      if (push) buf_q <= s_data;
      full_q <= (full_q & ~(stb & take)) | push;
      if (stb) begin
        st_q <= st_d; mon_q <= mon_d; e_n_q <= e_d;
        a_prev_q <= a_act; to_pend_q <= 1'b0;
      end else if (cmd_timeout) begin
        to_pend_q <= 1'b1;
      end
    end
  end

  assign mon_o    = mon_q;
  assign e_n_o    = e_n_q;
  assign arq_seen = stb & en & arq_c;

  // R1: line outputs frozen between strobes
  a_r1_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(stb) && $past(en)) |-> ($stable(mon_q) && $stable(e_n_q)))
    else $error("R1 transmit line changed without strobe");

  // R2: an accepted byte occupies the buffer
  a_r2_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> full_q)
    else $error("R2 accepted byte not held");

  // R3: end of message keeps E idle a second frame
  a_r3_eom_second: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en && proto && !to_now && st_q == TX_EOM) |=> (e_n_q && st_q == TX_IDLE))
    else $error("R3 end of message too short");

  // R4: timeout produces an abort frame
  a_r4_timeout_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en && to_now) |=> (!e_n_q && mon_q == IDLE_BYTE && st_q == TX_IDLE))
    else $error("R4 timeout abort missing");
endmodule

// File: rtl/gci_mon_rx.sv
`timescale 1ns/1ps
module gci_mon_rx #(
  parameter int W          = 8,
  parameter int ARQ_FRAMES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic         en,
  input  logic         proto,
  input  logic         cmd_abort_req,
  input  logic [W-1:0] line_mon,
  input  logic         line_a_n,
  input  logic         line_e_n,
  output logic         m_valid,
  output logic [W-1:0] m_data,
  output logic         m_a_n,
  output logic         m_e_n,
  input  logic         m_ready,
  output logic         a_n_o,
  output logic         abort_seen
);
  localparam int CW = $clog2(ARQ_FRAMES + 1);
  localparam logic [W-1:0] ABORT_BYTE = {W{1'b1}};

  logic [W-1:0] data_q;
  logic         full_q, ca_q, ce_q, ack_q, a_n_q, arq_pend_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic         pop, room, arq_now, store_c, abort_c, a_d, ack_d;

  assign pop     = full_q & m_ready;
  assign room    = ~full_q | pop;
  assign arq_now = proto & (arq_pend_q | cmd_abort_req);

  always_comb begin
    store_c = 1'b0;
    abort_c = 1'b0;
    a_d     = 1'b1;
    ack_d   = 1'b0;
    cnt_d   = cnt_q;
    if (arq_now) begin
      a_d = 1'b0; cnt_d = CW'(ARQ_FRAMES - 1);
    end else if (proto && cnt_q != '0) begin
      a_d = 1'b0; cnt_d = cnt_q - CW'(1);
    end else if (!proto) begin
      store_c = room; cnt_d = '0;
    end else if (ack_q) begin
      a_d = 1'b1;
    end else if (!line_e_n) begin
      if (line_mon == ABORT_BYTE) begin
        abort_c = 1'b1;
      end else if (room) begin
        store_c = 1'b1; a_d = 1'b0; ack_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0; full_q <= 1'b0; ca_q <= 1'b1; ce_q <= 1'b1;
      ack_q <= 1'b0; a_n_q <= 1'b1; arq_pend_q <= 1'b0; cnt_q <= '0;
    end else if (!en) begin
      full_q <= 1'b0; ack_q <= 1'b0; a_n_q <= 1'b1;
      arq_pend_q <= 1'b0; cnt_q <= '0;
    end else begin
      if (stb) begin
        a_n_q <= a_d; ack_q <= ack_d; cnt_q <= cnt_d; arq_pend_q <= 1'b0;
        if (store_c) begin
          data_q <= line_mon; ca_q <= line_a_n; ce_q <= line_e_n;
        end
      end else if (cmd_abort_req) begin
        arq_pend_q <= 1'b1;
      end
      if (stb && store_c) full_q <= 1'b1;
      else if (pop)       full_q <= 1'b0;
    end
  end

  assign m_valid    = full_q;
  assign m_data     = data_q;
  assign m_a_n      = ca_q;
  assign m_e_n      = ce_q;
  assign a_n_o      = a_n_q;
  assign abort_seen = stb & en & abort_c;

  // R1: outgoing A frozen between strobes
  a_r1_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(stb) && $past(en)) |-> $stable(a_n_q))
    else $error("R1 A changed without strobe");

  // R7: unread byte is never overwritten
  a_r7_keep_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !pop) |=> $stable(data_q))
    else $error("R7 unread byte overwritten");

  // R8: acknowledgement lasts one frame
  a_r8_ack_one_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en && proto && ack_q && !arq_now && cnt_q == '0) |=> a_n_q)
    else $error("R8 acknowledge longer than a frame");

  // R5: abort request drives A low
  a_r5_arq_low: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en && arq_now) |=> !a_n_q)
    else $error("R5 abort request not driven");
endmodule

// File: rtl/gci_mon_ctrl.sv
`timescale 1ns/1ps
module gci_mon_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_stb,
  input  logic         cfg_tx_en,
  input  logic         cfg_tx_proto,
  input  logic         cfg_rx_en,
  input  logic         cfg_rx_proto,
  input  logic         cfg_loop,
  input  logic         cfg_irq_en,
  input  logic         cmd_timeout,
  input  logic         cmd_abort_req,
  input  logic         abort_clr,
  input  logic         s_tx_valid,
  input  logic [W-1:0] s_tx_data,
  output logic         s_tx_ready,
  output logic         m_rx_valid,
  output logic [W-1:0] m_rx_data,
  output logic         m_rx_a_n,
  output logic         m_rx_e_n,
  input  logic         m_rx_ready,
  input  logic [W-1:0] line_rx_mon,
  input  logic         line_rx_a_n,
  input  logic         line_rx_e_n,
  output logic [W-1:0] line_tx_mon,
  output logic         line_tx_a_n,
  output logic         line_tx_e_n,
  output logic         irq,
  output logic         abort_flag
);
  logic [W-1:0] eff_mon;
  logic         eff_a_n, eff_e_n, tx_arq, rx_abort, flag_q;

  assign eff_mon = cfg_loop ? line_tx_mon : line_rx_mon;
  assign eff_a_n = cfg_loop ? line_tx_a_n : line_rx_a_n;
  assign eff_e_n = cfg_loop ? line_tx_e_n : line_rx_e_n;

  gci_mon_tx #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .en(cfg_tx_en),
    .proto(cfg_tx_proto), .cmd_timeout(cmd_timeout),
    .s_valid(s_tx_valid), .s_data(s_tx_data), .s_ready(s_tx_ready),
    .far_a_n(eff_a_n), .mon_o(line_tx_mon), .e_n_o(line_tx_e_n),
    .arq_seen(tx_arq)
  );

  gci_mon_rx #(.W(W), .ARQ_FRAMES(2)) u_rx (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .en(cfg_rx_en),
    .proto(cfg_rx_proto), .cmd_abort_req(cmd_abort_req),
    .line_mon(eff_mon), .line_a_n(eff_a_n), .line_e_n(eff_e_n),
    .m_valid(m_rx_valid), .m_data(m_rx_data), .m_a_n(m_rx_a_n),
    .m_e_n(m_rx_e_n), .m_ready(m_rx_ready), .a_n_o(line_tx_a_n),
    .abort_seen(rx_abort)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (tx_arq || rx_abort) flag_q <= 1'b1;
    else if (abort_clr)        flag_q <= 1'b0;
  end

  assign abort_flag = flag_q;
  assign irq        = cfg_irq_en & m_rx_valid;

  // R9 / R6: any detected abort leaves the flag set
  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_arq || rx_abort) |=> abort_flag)
    else $error("R9 abort flag not set");
endmodule

// File: tb/gci_mon_ctrl_test.sv
`timescale 1ns/1ps
module gci_mon_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 0, cfg_tx_en = 1, cfg_tx_proto = 0, cfg_rx_en = 0;
  logic cfg_rx_proto = 0, cfg_loop = 0, cfg_irq_en = 1;
  logic cmd_timeout = 0, cmd_abort_req = 0, abort_clr = 0;
  logic s_tx_valid = 0, m_rx_ready = 0;
  logic [7:0] s_tx_data = 8'h00, line_rx_mon = 8'hFF;
  logic line_rx_a_n = 1, line_rx_e_n = 1;
  logic s_tx_ready, m_rx_valid, m_rx_a_n, m_rx_e_n, line_tx_a_n, line_tx_e_n, irq, abort_flag;
  logic [7:0] m_rx_data, line_tx_mon;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gci_mon_ctrl uut (.*);

  // {push, data, expected mon, expected E}
  localparam logic [17:0] TBL [5] = '{
    {1'b1, 8'hA5, 8'hA5, 1'b0},
    {1'b0, 8'h00, 8'hFF, 1'b1},
    {1'b1, 8'h3C, 8'h3C, 1'b0},
    {1'b1, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'h00, 8'hFF, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) frame_stb = 1;
    @(negedge clk) frame_stb = 0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk) begin s_tx_valid = 1; s_tx_data = d; end
    @(negedge clk) s_tx_valid = 0;
  endtask

  task automatic rd();
    @(negedge clk) m_rx_ready = 1;
    @(negedge clk) m_rx_ready = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset mon", line_tx_mon, 8'hFF);
    chk("R12 reset E", line_tx_e_n, 1);
    chk("R12 reset A", line_tx_a_n, 1);
    chk("R2 reset ready", s_tx_ready, 1);
    chk("R10 reset irq", irq, 0);
    chk("R9 reset flag", abort_flag, 0);

    // R2 transparent transmit table
    for (int i = 0; i < 5; i++) begin
      logic p; logic [7:0] d, em; logic ee;
      {p, d, em, ee} = TBL[i];
      if (p) begin
        push(d);
        chk("R2 ready low when full", s_tx_ready, 0);
      end
      strobe();
      chk("R2 line byte", line_tx_mon, em);
      chk("R2 line E", line_tx_e_n, ee);
      chk("R2 ready after strobe", s_tx_ready, 1);
    end

    // R1 hold between strobes
    push(8'h77);
    repeat (3) @(negedge clk);
    chk("R1 byte held", line_tx_mon, 8'hFF);
    chk("R1 E held", line_tx_e_n, 1);
    strobe();
    chk("R1 byte after strobe", line_tx_mon, 8'h77);
    strobe();

    // R7 transparent receive, R10 irq
    cfg_rx_en = 1;
    line_rx_mon = 8'h11; line_rx_a_n = 0; line_rx_e_n = 1;
    strobe();
    chk("R7 stored valid", m_rx_valid, 1);
    chk("R7 stored byte", m_rx_data, 8'h11);
    chk("R7 raw A", m_rx_a_n, 0);
    chk("R7 raw E", m_rx_e_n, 1);
    chk("R10 irq on", irq, 1);
    cfg_irq_en = 0;
    @(negedge clk);
    chk("R10 irq masked", irq, 0);
    cfg_irq_en = 1;
    line_rx_mon = 8'h22;
    strobe();
    chk("R7 drop when full", m_rx_data, 8'h11);
    line_rx_mon = 8'h33;
    @(negedge clk) begin m_rx_ready = 1; frame_stb = 1; end
    @(negedge clk) begin m_rx_ready = 0; frame_stb = 0; end
    chk("R7 read+strobe stores new", m_rx_data, 8'h33);
    chk("R7 read+strobe valid", m_rx_valid, 1);
    rd();
    chk("R7 empty after read", m_rx_valid, 0);
    chk("R10 irq off", irq, 0);
    line_rx_a_n = 1;

    // R3, R8, R11 protocol loopback
    cfg_tx_proto = 1; cfg_rx_proto = 1; cfg_loop = 1;
    push(8'h5A);
    strobe();
    chk("R3 first byte", line_tx_mon, 8'h5A);
    chk("R3 first E", line_tx_e_n, 0);
    push(8'h6B);
    strobe();
    chk("R11 looped store", m_rx_data, 8'h5A);
    chk("R8 ack low", line_tx_a_n, 0);
    chk("R3 held until ack", line_tx_mon, 8'h5A);
    rd();
    strobe();
    chk("R8 no second store", m_rx_valid, 0);
    chk("R8 ack one frame", line_tx_a_n, 1);
    chk("R3 next byte", line_tx_mon, 8'h6B);
    strobe();
    chk("R8 second stored", m_rx_data, 8'h6B);
    strobe();
    chk("R3 eom E frame1", line_tx_e_n, 1);
    chk("R3 eom byte", line_tx_mon, 8'hFF);
    strobe();
    chk("R3 eom E frame2", line_tx_e_n, 1);
    rd();
    cfg_loop = 0;

    // R8 back-pressure without loopback
    line_rx_mon = 8'h44; line_rx_e_n = 0;
    strobe();
    chk("R8 store 44", m_rx_data, 8'h44);
    line_rx_mon = 8'h55;
    strobe();
    strobe();
    chk("R8 full not stored", m_rx_data, 8'h44);
    chk("R8 full no ack", line_tx_a_n, 1);
    rd();
    strobe();
    chk("R8 stored after read", m_rx_data, 8'h55);
    chk("R8 ack after read", line_tx_a_n, 0);
    strobe();
    rd();
    line_rx_e_n = 1;
    strobe();
    chk("R8 E high ignored", m_rx_valid, 0);

    // R9 received abort
    line_rx_mon = 8'hFF; line_rx_e_n = 0;
    strobe();
    chk("R9 flag set", abort_flag, 1);
    chk("R9 nothing stored", m_rx_valid, 0);
    chk("R9 no ack", line_tx_a_n, 1);
    line_rx_e_n = 1;
    @(negedge clk) abort_clr = 1;
    @(negedge clk) abort_clr = 0;
    chk("R9 flag cleared", abort_flag, 0);

    // R4 timeout
    push(8'h12);
    strobe();
    chk("R4 sending", line_tx_mon, 8'h12);
    push(8'h34);
    @(negedge clk) cmd_timeout = 1;
    @(negedge clk) cmd_timeout = 0;
    strobe();
    chk("R4 abort byte", line_tx_mon, 8'hFF);
    chk("R4 abort E", line_tx_e_n, 0);
    chk("R4 flushed", s_tx_ready, 1);
    strobe();
    chk("R4 idle after", line_tx_e_n, 1);
    chk("R4 no stale byte", line_tx_mon, 8'hFF);

    // R5 abort request
    @(negedge clk) cmd_abort_req = 1;
    @(negedge clk) cmd_abort_req = 0;
    strobe();
    chk("R5 A frame1", line_tx_a_n, 0);
    strobe();
    chk("R5 A frame2", line_tx_a_n, 0);
    strobe();
    chk("R5 A released", line_tx_a_n, 1);

    // R6 received abort request
    push(8'h09);
    strobe();
    push(8'h08);
    line_rx_a_n = 0;
    strobe();
    chk("R6 ack moves on", line_tx_mon, 8'h08);
    strobe();
    chk("R6 idle byte", line_tx_mon, 8'hFF);
    chk("R6 idle E", line_tx_e_n, 1);
    chk("R6 flag", abort_flag, 1);
    line_rx_a_n = 1;
    @(negedge clk) abort_clr = 1;
    @(negedge clk) abort_clr = 0;

    // R12 disable
    cfg_tx_proto = 0; cfg_rx_proto = 0;
    line_rx_mon = 8'h66;
    strobe();
    chk("R12 pre rx valid", m_rx_valid, 1);
    push(8'h21);
    @(negedge clk) begin cfg_tx_en = 0; cfg_rx_en = 0; end
    @(negedge clk);
    chk("R12 rx valid low", m_rx_valid, 0);
    chk("R12 ready low", s_tx_ready, 0);
    chk("R12 idle E", line_tx_e_n, 1);
    chk("R12 idle A", line_tx_a_n, 1);
    cfg_tx_en = 1;
    strobe();
    chk("R12 buffer emptied", line_tx_mon, 8'hFF);
    chk("R12 no stale E", line_tx_e_n, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule